// File: doc/BRIEF.md
# Segment Selector Descriptor Loader

This block reloads the hidden cache that sits behind each segment register. When software writes a new 16-bit selector into one of the segment registers, the loader splits the selector into an index, a table choice and a requested privilege level, finds the matching 8-byte descriptor in either the global or the local descriptor table, fetches it as two 32-bit words over a request/acknowledge read port, and writes the unpacked base, limit and access byte into the cache entry of that segment register.

The local table is reached indirectly. Its own base and limit live in a descriptor of the global table, picked by the selector held in the local table register. A load through the local table therefore costs two descriptor fetches. Both the table walk and the final entry are bounds-checked against the table limit. An out-of-range entry produces a one-cycle fault and leaves the cache entry untouched. A null selector clears the entry to invalid without any memory traffic.

The cache contents are read through a combinational lookup port addressed by segment number. The control sequence is a small state machine with six states: `ST_IDLE` (waiting for a selector write), `ST_LDT_LO` and `ST_LDT_HI` (fetching the local table's descriptor from the global table), `ST_TGT_CHK` (bounds check against the local table limit), and `ST_TGT_LO` and `ST_TGT_HI` (fetching the target descriptor).

Its transitions are as follows:
- `ST_IDLE` goes to `ST_TGT_LO` on an in-range global selector, to `ST_LDT_LO` on an in-range local selector, and stays put on null or faulting selectors.
- Each `_LO` state moves to its `_HI` state on acknowledge.
- `ST_LDT_HI` goes to `ST_TGT_CHK` on acknowledge.
- `ST_TGT_CHK` goes to `ST_IDLE` with a fault, or on to `ST_TGT_LO`.
- `ST_TGT_HI` goes back to `ST_IDLE` on acknowledge and writes the cache there.

Top module: `seg_desc_loader`

## Requirements
- R1: Selector bits 15:3 are the index, bit 2 picks the table (0 global, 1 local), bits 1:0 are the requested level; the requested level of the written selector is stored in the cache entry and shown on `rd_rpl`.
- R2: For a global selector the entry address is `gtab_base + 8*index`; the block reads the low word at that address, then the high word at address+4, then writes the entry of `sel_seg` as valid; `rd_*` show the entry selected by `rd_seg` combinationally.
- R3: From the low word `lo` and high word `hi`: base = {hi[31:24], hi[7:0], lo[31:16]}, limit (20 bits, bytes) = {hi[19:16], lo[15:0]}, access = hi[15:8]; bits hi[23:20] are ignored.
- R4: For a local selector the block first reads the global descriptor at `gtab_base + 8*L` (L = `ltab_sel[15:3]`; its bits 2:0 are ignored), takes its base and limit as the local table, then reads the target at local base + 8*index.
- R5: A table entry whose last byte offset 8*index+7 exceeds the table limit gives a one-cycle `fault` pulse, no further reads and an unchanged entry. A global target or a local table selector (checked against `gtab_limit`, and also faulting when L is 0) faults one cycle after the write, with no busy cycle. A local target faults one cycle after its table descriptor's high word is acknowledged.
- R6: `mem_req` is high only while `busy`; once raised it holds with a stable `mem_addr` until `mem_ack`; if the acknowledge stays low for D cycles each read takes D+1 cycles, so `busy` lasts 2(D+1) cycles for a global load, 4(D+1)+1 for a local load, and 2(D+1)+1 for a local target fault.
- R7: A selector with index 0 and table bit 0 is null: the entry becomes invalid with base, limit and access 0 and the written requested level, with no memory read and no busy cycle.
- R8: A selector write while `busy` is high is ignored: no entry changes because of it and no read is issued for it.
- R9: After reset every entry is invalid with all fields 0, and `busy`, `fault` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_wr | input | 1 | Selector write strobe |
| sel_seg | input | 2 | Segment register being written |
| sel_val | input | 16 | New selector value |
| gtab_base | input | 32 | Global table base address |
| gtab_limit | input | 16 | Global table limit in bytes |
| ltab_sel | input | 16 | Selector naming the local table in the global table |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read byte address |
| mem_ack | input | 1 | Read acknowledge, data valid this cycle |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | A descriptor fetch is in progress |
| fault | output | 1 | One-cycle limit violation pulse |
| rd_seg | input | 2 | Cache entry to show |
| rd_valid | output | 1 | Entry valid |
| rd_rpl | output | 2 | Entry requested level |
| rd_access | output | 8 | Entry access byte |
| rd_limit | output | 20 | Entry limit |
| rd_base | output | 32 | Entry base |

## Verification
The reference model predicts each result at a known cycle. An early fault or a null load shows one cycle after the write edge, with `busy` never high. `busy` rises one cycle after the write and stays high for exactly 2(D+1), 2(D+1)+1 or 4(D+1)+1 cycles, with the acknowledge delay D set by the bench's memory. A late fault coincides with the first cycle `busy` is low again, and a new cache entry is visible from that same cycle. The bench samples on falling edges, counts busy and fault cycles across the whole window, and records every acknowledged address in a queue that it compares against the model's queue. The whole cache is then read back through the lookup port.

// File: rtl/seg_ld_pkg.sv
package seg_ld_pkg;
    localparam int SEL_W  = 16;
    localparam int IDX_W  = 13;
    localparam int BASE_W = 32;
    localparam int LIM_W  = 20;
    localparam int ACC_W  = 8;
    localparam int RPL_W  = 2;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic               valid;
        logic [RPL_W-1:0]   rpl;
        logic [ACC_W-1:0]   access;
        logic [LIM_W-1:0]   limit;
        logic [BASE_W-1:0]  base;
    } seg_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LDT_LO,
        ST_LDT_HI,
        ST_TGT_CHK,
        ST_TGT_LO,
        ST_TGT_HI
    } ld_state_t;
endpackage

// File: rtl/seg_ld_addr.sv
module seg_ld_addr
    import seg_ld_pkg::*;
(
    input  logic [BASE_W-1:0] tbl_base,
    input  logic [LIM_W-1:0]  tbl_limit,
    input  logic [IDX_W-1:0]  index,
    output logic [BASE_W-1:0] entry_addr,
    output logic              over_limit
);
    localparam int SPAN_W = LIM_W + 1;

    logic [SPAN_W-1:0] last_byte;

    always_comb begin
        entry_addr = tbl_base + {{(BASE_W-IDX_W-3){1'b0}}, index, 3'b000};
        last_byte  = {{(SPAN_W-IDX_W-3){1'b0}}, index, 3'b111};
        over_limit = last_byte > {1'b0, tbl_limit};
    end
endmodule

// File: rtl/seg_ld_unpack.sv
module seg_ld_unpack
    import seg_ld_pkg::*;
(
    input  logic [WORD_W-1:0] lo_word,
    input  logic [WORD_W-1:0] hi_word,
    output logic [BASE_W-1:0] base,
    output logic [LIM_W-1:0]  limit,
    output logic [ACC_W-1:0]  access
);
    logic unused_flags;

    always_comb begin
        base         = {hi_word[31:24], hi_word[7:0], lo_word[31:16]};
        limit        = {hi_word[19:16], lo_word[15:0]};
        access       = hi_word[15:8];
        unused_flags = ^hi_word[23:20];
    end
endmodule

// File: rtl/seg_ld_cache.sv
module seg_ld_cache
    import seg_ld_pkg::*;
#(
    parameter int NUM_SEG = 4,
    parameter int SEG_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  seg_entry_t       wr_data,
    input  logic [SEG_W-1:0] rd_idx,
    output seg_entry_t       rd_data
);
    seg_entry_t ent_q [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
            end else if (wr_en && (wr_idx == SEG_W'(g))) begin
                ent_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (rd_idx == SEG_W'(i)) begin
                rd_data = ent_q[i];
            end
        end
    end
endmodule

// File: rtl/seg_desc_loader.sv
module seg_desc_loader
    import seg_ld_pkg::*;
#(
    parameter int NUM_SEG = 4,
    localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [SEG_W-1:0]  sel_seg,
    input  logic [15:0]       sel_val,
    input  logic [31:0]       gtab_base,
    input  logic [15:0]       gtab_limit,
    input  logic [15:0]       ltab_sel,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              busy,
    output logic              fault,
    input  logic [SEG_W-1:0]  rd_seg,
    output logic              rd_valid,
    output logic [1:0]        rd_rpl,
    output logic [7:0]        rd_access,
    output logic [19:0]       rd_limit,
    output logic [31:0]       rd_base
);
    ld_state_t          state_q, state_d;
    logic [SEL_W-1:0]   sel_q, sel_d;
    logic [SEG_W-1:0]   seg_q, seg_d;
    logic [BASE_W-1:0]  tbase_q, tbase_d;
    logic [LIM_W-1:0]   tlim_q, tlim_d;
    logic [WORD_W-1:0]  lo_q, lo_d;
    logic               fault_q, fault_d;

    logic               in_ti, in_null;
    logic [IDX_W-1:0]   g_idx, lsel_idx;
    logic [BASE_W-1:0]  g_addr, t_addr;
    logic               g_over, t_over;
    logic [BASE_W-1:0]  u_base;
    logic [LIM_W-1:0]   u_limit;
    logic [ACC_W-1:0]   u_access;
    logic               cw_en;
    logic [SEG_W-1:0]   cw_idx;
    seg_entry_t         cw_data, rd_ent;
    logic               unused_lsel;

    assign in_ti       = sel_val[2];
    assign in_null     = (sel_val[15:3] == '0) && !sel_val[2];
    assign lsel_idx    = ltab_sel[15:3];
    assign g_idx       = in_ti ? lsel_idx : sel_val[15:3];
    assign unused_lsel = ^ltab_sel[2:0];

    // Lookups in the global table made straight from the written selector
    seg_ld_addr u_gaddr (
        .tbl_base   (gtab_base),
        .tbl_limit  (LIM_W'(gtab_limit)),
        .index      (g_idx),
        .entry_addr (g_addr),
        .over_limit (g_over)
    );

    // Target entry in the table latched for this load
    seg_ld_addr u_taddr (
        .tbl_base   (tbase_q),
        .tbl_limit  (tlim_q),
        .index      (sel_q[15:3]),
        .entry_addr (t_addr),
        .over_limit (t_over)
    );

    seg_ld_unpack u_unpack (
        .lo_word (lo_q),
        .hi_word (mem_rdata),
        .base    (u_base),
        .limit   (u_limit),
        .access  (u_access)
    );

    seg_ld_cache #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W)) u_cache (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cw_en),
        .wr_idx  (cw_idx),
        .wr_data (cw_data),
        .rd_idx  (rd_seg),
        .rd_data (rd_ent)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
            seg_q   <= '0;
            tbase_q <= '0;
            tlim_q  <= '0;
            lo_q    <= '0;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
            seg_q   <= seg_d;
            tbase_q <= tbase_d;
            tlim_q  <= tlim_d;
            lo_q    <= lo_d;
            fault_q <= fault_d;
        end
    end

    // Next state and captured datapath
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        seg_d   = seg_q;
        tbase_d = tbase_q;
        tlim_d  = tlim_q;
        lo_d    = lo_q;
        fault_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sel_wr) begin
                    sel_d = sel_val;
                    seg_d = sel_seg;
                    if (in_null) begin
                        state_d = ST_IDLE;
                    end else if (!in_ti) begin
                        if (g_over) begin
                            fault_d = 1'b1;
                        end else begin
                            tbase_d = gtab_base;
                            tlim_d  = LIM_W'(gtab_limit);
                            state_d = ST_TGT_LO;
                        end
                    end else begin
                        if (g_over || (lsel_idx == '0)) begin
                            fault_d = 1'b1;
                        end else begin
                            tbase_d = g_addr;
                            state_d = ST_LDT_LO;
                        end
                    end
                end
            end
            ST_LDT_LO: begin
                if (mem_ack) begin
                    lo_d    = mem_rdata;
                    state_d = ST_LDT_HI;
                end
            end
            ST_LDT_HI: begin
                if (mem_ack) begin
                    tbase_d = u_base;
                    tlim_d  = u_limit;
                    state_d = ST_TGT_CHK;
                end
            end
            ST_TGT_CHK: begin
                if (t_over) begin
                    fault_d = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_TGT_LO;
                end
            end
            ST_TGT_LO: begin
                if (mem_ack) begin
                    lo_d    = mem_rdata;
                    state_d = ST_TGT_HI;
                end
            end
            ST_TGT_HI: begin
                if (mem_ack) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and cache write
    always_comb begin
        busy    = 1'b0;
        mem_req = 1'b0;
        mem_addr = '0;
        cw_en   = 1'b0;
        cw_idx  = seg_q;
        cw_data = '0;
        unique case (state_q)
            ST_IDLE: begin
                cw_idx = sel_seg;
                if (sel_wr && in_null) begin
                    cw_en       = 1'b1;
                    cw_data.rpl = sel_val[1:0];
                end
            end
            ST_LDT_LO: begin
                busy     = 1'b1;
                mem_req  = 1'b1;
                mem_addr = tbase_q;
            end
            ST_LDT_HI: begin
                busy     = 1'b1;
                mem_req  = 1'b1;
                mem_addr = tbase_q + 32'd4;
            end
            ST_TGT_CHK: begin
                busy = 1'b1;
            end
            ST_TGT_LO: begin
                busy     = 1'b1;
                mem_req  = 1'b1;
                mem_addr = t_addr;
            end
            ST_TGT_HI: begin
                busy     = 1'b1;
                mem_req  = 1'b1;
                mem_addr = t_addr + 32'd4;
                if (mem_ack) begin
                    cw_en          = 1'b1;
                    cw_data.valid  = 1'b1;
                    cw_data.rpl    = sel_q[1:0];
                    cw_data.access = u_access;
                    cw_data.limit  = u_limit;
                    cw_data.base   = u_base;
                end
            end
            default: busy = 1'b0;
        endcase
    end

    assign fault     = fault_q;
    assign rd_valid  = rd_ent.valid;
    assign rd_rpl    = rd_ent.rpl;
    assign rd_access = rd_ent.access;
    assign rd_limit  = rd_ent.limit;
    assign rd_base   = rd_ent.base;
endmodule

// File: rtl/seg_ld_chk.sv
module seg_ld_chk #(
    parameter int SEG_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_wr,
    input logic [15:0]      sel_val,
    input logic             mem_req,
    input logic [31:0]      mem_addr,
    input logic             mem_ack,
    input logic             busy,
    input logic             fault,
    input logic [SEG_W-1:0] rd_seg
);
    // R6: requests only inside a busy window
    a_r6_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R6: request and address hold until acknowledged
    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R2: the high word request follows the low word at +4
    a_r2_hi_after_lo: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_req && mem_ack) && mem_req) |-> (mem_addr == $past(mem_addr) + 32'd4));

    // R5: a fault is reported with the loader back at rest
    a_r5_fault_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !busy);

    // R7: a null selector starts no fetch
    a_r7_null_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && !busy && (sel_val[15:2] == 14'd0)) |=> (!busy && !mem_req && !fault));

    logic unused_rd;
    assign unused_rd = ^rd_seg;
endmodule

bind seg_desc_loader seg_ld_chk #(.SEG_W(SEG_W)) u_seg_ld_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_wr   (sel_wr),
    .sel_val  (sel_val),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .busy     (busy),
    .fault    (fault),
    .rd_seg   (rd_seg)
);

// File: tb/tb_seg_desc_loader.sv
`timescale 1ns/1ps
module tb_seg_desc_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_wr = 1'b0;
    logic [1:0]  sel_seg = '0;
    logic [15:0] sel_val = '0;
    logic [31:0] gtab_base = 32'h0001_0000;
    logic [15:0] gtab_limit = 16'h00FF;
    logic [15:0] ltab_sel = {13'd5, 3'b000};
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy, fault;
    logic [1:0]  rd_seg = '0;
    logic        rd_valid;
    logic [1:0]  rd_rpl;
    logic [7:0]  rd_access;
    logic [19:0] rd_limit;
    logic [31:0] rd_base;

    always #5 clk = ~clk;

    seg_desc_loader dut (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_seg(sel_seg), .sel_val(sel_val),
        .gtab_base(gtab_base), .gtab_limit(gtab_limit), .ltab_sel(ltab_sel),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .fault(fault), .rd_seg(rd_seg), .rd_valid(rd_valid), .rd_rpl(rd_rpl),
        .rd_access(rd_access), .rd_limit(rd_limit), .rd_base(rd_base)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench memory and reference cache
    logic [31:0] mem [int unsigned];
    logic [62:0] m_ent [4];
    int          ack_dly = 0;
    int          wcnt = 0;
    logic [31:0] got_q [$];
    logic [31:0] exp_q [$];

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic put_desc(input logic [31:0] a, input logic [31:0] b,
                            input logic [19:0] l, input logic [7:0] acc);
        mem[a]     = {b[15:0], l[15:0]};
        mem[a + 4] = {b[31:24], 4'hC, l[19:16], acc, b[23:16]};
    endtask

    function automatic logic [15:0] mk_sel(input int idx, input bit ti, input int rpl);
        return {idx[12:0], ti, rpl[1:0]};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory responder: acknowledge after ack_dly low cycles
    always @(negedge clk) begin
        if (mem_req) begin
            if (wcnt >= ack_dly) begin
                mem_ack   <= 1'b1;
                mem_rdata <= rd_mem(mem_addr);
                got_q.push_back(mem_addr);
                wcnt      <= 0;
            end else begin
                mem_ack <= 1'b0;
                wcnt    <= wcnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end
    end

    // Reference model of one selector write
    task automatic model(input int seg, input logic [15:0] s, input int d,
                         output int e_busy, output int e_fault);
        int idx, lidx;
        logic [31:0] a, lo, hi, lb;
        logic [19:0] ll;
        idx = int'(s[15:3]);
        lidx = int'(ltab_sel[15:3]);
        e_busy = 0;
        e_fault = 0;
        exp_q.delete();
        if (idx == 0 && !s[2]) begin
            m_ent[seg] = {1'b0, s[1:0], 60'h0};
        end else if (!s[2]) begin
            if (idx * 8 + 7 > int'(gtab_limit)) begin
                e_fault = 1;
            end else begin
                a = gtab_base + 32'(idx * 8);
                exp_q.push_back(a); exp_q.push_back(a + 4);
                lo = rd_mem(a); hi = rd_mem(a + 4);
                m_ent[seg] = {1'b1, s[1:0], hi[15:8], hi[19:16], lo[15:0], hi[31:24], hi[7:0], lo[31:16]};
                e_busy = 2 * (d + 1);
            end
        end else begin
            if (lidx == 0 || lidx * 8 + 7 > int'(gtab_limit)) begin
                e_fault = 1;
            end else begin
                a = gtab_base + 32'(lidx * 8);
                exp_q.push_back(a); exp_q.push_back(a + 4);
                lo = rd_mem(a); hi = rd_mem(a + 4);
                lb = {hi[31:24], hi[7:0], lo[31:16]};
                ll = {hi[19:16], lo[15:0]};
                if (idx * 8 + 7 > int'(ll)) begin
                    e_fault = 1;
                    e_busy = 2 * (d + 1) + 1;
                end else begin
                    a = lb + 32'(idx * 8);
                    exp_q.push_back(a); exp_q.push_back(a + 4);
                    lo = rd_mem(a); hi = rd_mem(a + 4);
                    m_ent[seg] = {1'b1, s[1:0], hi[15:8], hi[19:16], lo[15:0], hi[31:24], hi[7:0], lo[31:16]};
                    e_busy = 4 * (d + 1) + 1;
                end
            end
        end
    endtask

    task automatic check_cache(input string tag);
        for (int i = 0; i < 4; i++) begin
            rd_seg = 2'(i);
            #1;
            chk(tag, {1'b0, rd_valid, rd_rpl, rd_access, rd_limit, rd_base}, {1'b0, m_ent[i]});
        end
    endtask

    // One selector write; optional second write injected while busy
    task automatic run_op(input string tag, input int seg, input logic [15:0] s, input int d,
                          input bit inject, input int iseg, input logic [15:0] isel);
        int e_busy, e_fault, bc, fc;
        model(seg, s, d, e_busy, e_fault);
        @(negedge clk);
        ack_dly = d;
        got_q.delete();
        sel_wr = 1'b1; sel_seg = 2'(seg); sel_val = s;
        @(negedge clk);
        sel_wr = 1'b0;
        bc = 0; fc = 0;
        forever begin
            if (fault) fc++;
            if (!busy) break;
            bc++;
            if (inject && bc == 1) begin
                sel_wr = 1'b1; sel_seg = 2'(iseg); sel_val = isel;
            end else begin
                sel_wr = 1'b0;
            end
            @(negedge clk);
        end
        sel_wr = 1'b0;
        chk({tag, " R6 busy cycles"}, 64'(bc), 64'(e_busy));
        chk({tag, " R5 fault pulses"}, 64'(fc), 64'(e_fault));
        chk({tag, " read count"}, 64'(got_q.size()), 64'(exp_q.size()));
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk({tag, " read address"}, 64'(got_q[i]), 64'(exp_q[i]));
        check_cache({tag, " cache"});
    endtask

    initial begin
        put_desc(32'h0001_0008, 32'h1234_5678, 20'hABCDE, 8'h92);
        put_desc(32'h0001_0010, 32'h0F0E_0D0C, 20'h00FFF, 8'h93);
        put_desc(32'h0001_00F8, 32'hCAFE_0000, 20'h00010, 8'h9A);
        put_desc(32'h0001_0028, 32'h0002_0000, 20'h0003F, 8'h82);
        put_desc(32'h0002_0000, 32'h7000_0100, 20'h12345, 8'hB3);
        put_desc(32'h0002_0038, 32'h0BAD_1000, 20'h54321, 8'hF2);
        for (int i = 0; i < 4; i++) m_ent[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 busy after reset", 64'(busy), 64'd0);
        chk("R9 fault after reset", 64'(fault), 64'd0);
        chk("R9 mem_req after reset", 64'(mem_req), 64'd0);
        check_cache("R9 reset cache");

        run_op("R2 R3 R1 global idx1", 0, mk_sel(1, 0, 3), 0, 0, 0, 16'h0);
        run_op("R2 R6 global last idx", 1, mk_sel(31, 0, 0), 2, 0, 0, 16'h0);
        run_op("R5 global over limit", 2, mk_sel(32, 0, 1), 0, 0, 0, 16'h0);
        run_op("R4 R3 local idx7", 2, mk_sel(7, 1, 2), 1, 0, 0, 16'h0);
        run_op("R5 R4 local over limit", 3, mk_sel(8, 1, 1), 0, 0, 0, 16'h0);
        run_op("R7 null selector", 0, mk_sel(0, 0, 2), 0, 0, 0, 16'h0);
        run_op("R4 R7 local idx0 not null", 3, mk_sel(0, 1, 0), 1, 0, 0, 16'h0);
        run_op("R8 write while busy", 1, mk_sel(2, 0, 1), 3, 1, 3, mk_sel(1, 0, 0));
        ltab_sel = {13'd40, 3'b000};
        run_op("R5 local table sel over", 3, mk_sel(1, 1, 0), 0, 0, 0, 16'h0);
        ltab_sel = {13'd0, 3'b111};
        run_op("R5 local table sel zero", 3, mk_sel(1, 1, 0), 0, 0, 0, 16'h0);
        ltab_sel = {13'd5, 3'b111};
        run_op("R4 local sel low bits ignored", 0, mk_sel(7, 1, 1), 0, 0, 0, 16'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R6 actual=hung expected=idle");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule